// File: doc/BRIEF.md
# Multi-Vector Accumulate Row Sequencer

This block turns one decoded multi-vector multiply-accumulate operation into the ordered set of register-file accesses it needs. A group has two or four members. For each member it gives two vector source indices and one accumulator row index. That row is read as the addend and later written with the result. The block also reports the element width and lane count to an external lane-parallel multiply-add unit. The unit has no predicate, so it updates every lane.

The accumulator array holds VLEN/8 rows, where VLEN is the vector length in bits. A group spreads its rows evenly across the array. The spacing equals the row count divided by the group count. The first row is the value of a 32-bit select register plus a 3-bit offset, reduced modulo that spacing. A start pulse loads the fields. Members are then handed over one per accepted valid/ready transfer, and a done pulse closes the operation. An operation whose precision support is switched off raises a one-cycle exception together with done and issues nothing.

Top module: `mvacc_row_seq`

## Requirements
- R1: `sel_idx` always equals binary `10` followed by `sel_fld`, so only select registers 8 to 11 can be named.
- R2: The source base index is `{src_fld,0}` for a group of two and `{src_fld[2:0],00}` for a group of four. Member r reads sources base_a+r and base_b+r.
- R3: With ROWS = VLEN/8 and stride = ROWS/2 (`grp4`=0) or ROWS/4 (`grp4`=1), member 0 uses row (sel_val + ofs) mod stride.
- R4: Each later member uses the previous member's row plus stride. One `acc_row` index serves both the addend read and the write-back.
- R5: Element width is 16 when `half_var`=1, otherwise 32 when `size_bit`=0 and 64 when it is 1. `lanes` equals VLEN divided by that width. Both hold from the first member until the next accepted start.
- R6: An operation is undefined when `half_var`=1 and `half_en`=0, or when `half_var`=0, `size_bit`=1 and `dbl_en`=0. Its start leads, one cycle later, to `undef_exc` and `done` high for exactly one cycle, and `op_valid` never rises.
- R7: A member is offered with `op_valid`=1. While `op_ready`=0 the block keeps `op_valid` high and all indices unchanged. Each accepted transfer advances exactly one member, in order 0 upward.
- R8: `done` pulses for one cycle, in the cycle after the last member's transfer, and `op_valid` is low in that cycle. The operation has exactly two or four transfers.
- R9: A `start` that arrives while an operation is in progress has no effect on that operation.
- R10: After reset, `op_valid`, `done` and `undef_exc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| size_bit | input | 1 | Precision select: 0 single, 1 double |
| sel_fld | input | 2 | Select-register field |
| src_a_fld | input | 4 | First source register field |
| src_b_fld | input | 4 | Second source register field |
| ofs | input | 3 | Row offset |
| grp4 | input | 1 | 0: group of two, 1: group of four |
| half_var | input | 1 | Half-precision variant |
| sel_val | input | 32 | Value of the chosen select register |
| dbl_en | input | 1 | Double-precision support enabled |
| half_en | input | 1 | Half-precision support enabled |
| sel_idx | output | 4 | Index of the select register to read |
| op_valid | output | 1 | A member operation is offered |
| op_ready | input | 1 | Multiply-add unit accepts the member |
| rd_a_idx | output | 5 | First source register index |
| rd_b_idx | output | 5 | Second source register index |
| acc_row | output | ROW_W | Accumulator row to read and write back |
| elem_bits | output | 7 | Element width in bits |
| lanes | output | LANE_W | Lanes per row |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one cycle) |
| undef_exc | output | 1 | Undefined operation (one cycle) |

## Verification
The assertions assume that `sel_val` and the field inputs are steady in the cycle where `start` is accepted. They also assume that `op_ready` is a plain level that the block never has to wait on past the run. The stimulus changes fields and `start` only on the falling clock edge, away from the sampling edge. It drives `op_ready` either always high or in a repeating stall pattern, so held-index cycles occur next to back-to-back transfers. The restart cases put new fields on the inputs together with the ignored pulse, so a wrongly latched start would show in the indices.

// File: rtl/mvacc_pkg.sv
package mvacc_pkg;
  // Element width in bits for the chosen variant.
  function automatic logic [6:0] elem_width(input logic half, input logic sz);
    if (half) return 7'd16;
    return sz ? 7'd64 : 7'd32;
  endfunction

  // log2 of the element width, used to derive the lane count by shifting.
  function automatic int unsigned elem_log2(input logic half, input logic sz);
    if (half) return 4;
    return sz ? 6 : 5;
  endfunction

  // First source register of a group: field scaled by the group size.
  function automatic logic [4:0] src_base(input logic [3:0] fld, input logic four);
    return four ? {fld[2:0], 2'b00} : {fld, 1'b0};
  endfunction

  // Undefined when the requested precision is switched off.
  function automatic logic op_undef(input logic half, input logic sz,
                                    input logic d_en, input logic h_en);
    return half ? !h_en : (sz && !d_en);
  endfunction
endpackage

// File: rtl/mvacc_decode.sv
module mvacc_decode
  import mvacc_pkg::*;
#(
  parameter int VLEN = 512
) (
  input  logic                                 size_bit,
  input  logic [3:0]                           src_a_fld,
  input  logic [3:0]                           src_b_fld,
  input  logic [2:0]                           ofs,
  input  logic                                 grp4,
  input  logic                                 half_var,
  input  logic [31:0]                          sel_val,
  input  logic                                 dbl_en,
  input  logic                                 half_en,
  output logic                                 legal,
  output logic [4:0]                           base_a,
  output logic [4:0]                           base_b,
  output logic [$clog2(VLEN/8)-1:0]            first_row,
  output logic [$clog2(VLEN/8)-1:0]            stride,
  output logic [6:0]                           esize,
  output logic [$clog2(VLEN/16):0]             lanes
);
  localparam int ROWS   = VLEN / 8;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int LANE_W = $clog2(VLEN/16) + 1;
  localparam logic [ROW_W-1:0] STR_TWO  = ROW_W'(ROWS / 2);
  localparam logic [ROW_W-1:0] STR_FOUR = ROW_W'(ROWS / 4);

  logic [31:0] row_sum;

  always_comb begin
    legal     = !op_undef(half_var, size_bit, dbl_en, half_en);
    base_a    = src_base(src_a_fld, grp4);
    base_b    = src_base(src_b_fld, grp4);
    stride    = grp4 ? STR_FOUR : STR_TWO;
    row_sum   = sel_val + {29'd0, ofs};
    first_row = row_sum[ROW_W-1:0] & (stride - ROW_W'(1));
    esize     = elem_width(half_var, size_bit);
    lanes     = LANE_W'(VLEN >> elem_log2(half_var, size_bit));
  end
endmodule

// File: rtl/mvacc_seq.sv
module mvacc_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       legal,
  input  logic       grp4,
  input  logic       ready,
  output logic       busy,
  output logic       load,
  output logic       advance,
  output logic       last,
  output logic [1:0] cnt,
  output logic       done,
  output logic       exc
);
  logic grp4_q;

  assign load    = start && !busy && legal;
  assign advance = busy && ready;
  assign last    = (cnt == (grp4_q ? 2'd3 : 2'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= 2'd0;
      grp4_q <= 1'b0;
      done   <= 1'b0;
      exc    <= 1'b0;
    end else begin
      done <= 1'b0;
      exc  <= 1'b0;
      if (!busy && start) begin
        if (legal) begin
          busy   <= 1'b1;
          cnt    <= 2'd0;
          grp4_q <= grp4;
        end else begin
          done <= 1'b1;
          exc  <= 1'b1;
        end
      end else if (advance) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 2'd1;
        end
      end
    end
  end

  // R6: exception lasts one cycle and always comes with done
  p_exc_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> done ##1 !exc);
  // R8: after the last transfer, done follows and nothing is offered
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && last) |=> (done && !busy));
  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(start));
endmodule

// File: rtl/mvacc_addr.sv
module mvacc_addr #(
  parameter int ROW_W  = 6,
  parameter int LANE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [4:0]        base_a,
  input  logic [4:0]        base_b,
  input  logic [ROW_W-1:0]  first_row,
  input  logic [ROW_W-1:0]  stride,
  input  logic [6:0]        esize,
  input  logic [LANE_W-1:0] lanes,
  input  logic [1:0]        cnt,
  output logic [4:0]        rd_a,
  output logic [4:0]        rd_b,
  output logic [ROW_W-1:0]  row,
  output logic [6:0]        esize_q,
  output logic [LANE_W-1:0] lanes_q
);
  logic [4:0]       base_a_q, base_b_q;
  logic [ROW_W-1:0] first_q, stride_q;

  // Row of member k: first row plus k strides (never exceeds the array).
  function automatic logic [ROW_W-1:0] member_row(input logic [ROW_W-1:0] f,
                                                  input logic [ROW_W-1:0] s,
                                                  input logic [1:0] k);
    logic [ROW_W-1:0] acc;
    acc = f;
    for (int i = 0; i < 3; i++)
      if (i < int'(k)) acc = acc + s;
    return acc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a_q <= '0;
      base_b_q <= '0;
      first_q  <= '0;
      stride_q <= '0;
      esize_q  <= '0;
      lanes_q  <= '0;
    end else if (load) begin
      base_a_q <= base_a;
      base_b_q <= base_b;
      first_q  <= first_row;
      stride_q <= stride;
      esize_q  <= esize;
      lanes_q  <= lanes;
    end
  end

  assign rd_a = base_a_q + {3'd0, cnt};
  assign rd_b = base_b_q + {3'd0, cnt};
  assign row  = member_row(first_q, stride_q, cnt);
endmodule

// File: rtl/mvacc_row_seq.sv
module mvacc_row_seq
  import mvacc_pkg::*;
#(
  parameter int VLEN   = 512,
  parameter int ROW_W  = $clog2(VLEN/8),
  parameter int LANE_W = $clog2(VLEN/16) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              size_bit,
  input  logic [1:0]        sel_fld,
  input  logic [3:0]        src_a_fld,
  input  logic [3:0]        src_b_fld,
  input  logic [2:0]        ofs,
  input  logic              grp4,
  input  logic              half_var,
  input  logic [31:0]       sel_val,
  input  logic              dbl_en,
  input  logic              half_en,
  output logic [3:0]        sel_idx,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [4:0]        rd_a_idx,
  output logic [4:0]        rd_b_idx,
  output logic [ROW_W-1:0]  acc_row,
  output logic [6:0]        elem_bits,
  output logic [LANE_W-1:0] lanes,
  output logic              busy,
  output logic              done,
  output logic              undef_exc
);
  logic             legal, load, advance, last;
  logic [1:0]       cnt;
  logic [4:0]       base_a, base_b;
  logic [ROW_W-1:0] first_row, stride;
  logic [6:0]       esize;
  logic [LANE_W-1:0] lanes_d;

  assign sel_idx = {2'b10, sel_fld};

  mvacc_decode #(.VLEN(VLEN)) u_dec (
    .size_bit(size_bit), .src_a_fld(src_a_fld), .src_b_fld(src_b_fld),
    .ofs(ofs), .grp4(grp4), .half_var(half_var), .sel_val(sel_val),
    .dbl_en(dbl_en), .half_en(half_en), .legal(legal),
    .base_a(base_a), .base_b(base_b), .first_row(first_row),
    .stride(stride), .esize(esize), .lanes(lanes_d)
  );

  mvacc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .legal(legal), .grp4(grp4),
    .ready(op_ready), .busy(busy), .load(load), .advance(advance),
    .last(last), .cnt(cnt), .done(done), .exc(undef_exc)
  );

  mvacc_addr #(.ROW_W(ROW_W), .LANE_W(LANE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .base_a(base_a), .base_b(base_b),
    .first_row(first_row), .stride(stride), .esize(esize), .lanes(lanes_d),
    .cnt(cnt), .rd_a(rd_a_idx), .rd_b(rd_b_idx), .row(acc_row),
    .esize_q(elem_bits), .lanes_q(lanes)
  );

  assign op_valid = busy;

  // R7: a stalled offer stays up with unchanged indices
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(rd_a_idx)
                                 && $stable(rd_b_idx) && $stable(acc_row)));
  // R2: sources step by one between members
  p_src_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !last) |=> (rd_a_idx == $past(rd_a_idx) + 5'd1)
                        && (rd_b_idx == $past(rd_b_idx) + 5'd1));
  // R4: rows step by the stride between members
  p_row_stride_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !last) |=> (acc_row - $past(acc_row)) == (grp4_run_stride));
  // R9: a start during a run leaves the reported width and lanes alone
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(elem_bits) && $stable(lanes)));
  // R6: an undefined operation never offers a member
  p_undef_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !legal) |=> (undef_exc && !op_valid));

  logic [ROW_W-1:0] grp4_run_stride;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    grp4_run_stride <= '0;
    else if (load) grp4_run_stride <= stride;
  end
endmodule

// File: tb/mvacc_row_seq_test.sv
module mvacc_row_seq_test;
  localparam int VLEN   = 512;
  localparam int ROWS   = VLEN / 8;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int LANE_W = $clog2(VLEN/16) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, size_bit = 1'b0, grp4 = 1'b0, half_var = 1'b0;
  logic dbl_en = 1'b0, half_en = 1'b0, op_ready = 1'b1;
  logic [1:0] sel_fld = '0;
  logic [3:0] src_a_fld = '0, src_b_fld = '0;
  logic [2:0] ofs = '0;
  logic [31:0] sel_val = '0;
  logic [3:0] sel_idx;
  logic op_valid, busy, done, undef_exc;
  logic [4:0] rd_a_idx, rd_b_idx;
  logic [ROW_W-1:0] acc_row;
  logic [6:0] elem_bits;
  logic [LANE_W-1:0] lanes;

  always #10 clk = ~clk;

  mvacc_row_seq #(.VLEN(VLEN)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .size_bit(size_bit),
    .sel_fld(sel_fld), .src_a_fld(src_a_fld), .src_b_fld(src_b_fld),
    .ofs(ofs), .grp4(grp4), .half_var(half_var), .sel_val(sel_val),
    .dbl_en(dbl_en), .half_en(half_en), .sel_idx(sel_idx),
    .op_valid(op_valid), .op_ready(op_ready), .rd_a_idx(rd_a_idx),
    .rd_b_idx(rd_b_idx), .acc_row(acc_row), .elem_bits(elem_bits),
    .lanes(lanes), .busy(busy), .done(done), .undef_exc(undef_exc)
  );

  typedef struct { int a; int b; int row; } exp_t;
  exp_t q[$];

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  bit stall_mode = 0;
  int rdy_cnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ready pattern, changed only on the falling edge
  always @(negedge clk) begin
    rdy_cnt++;
    op_ready <= stall_mode ? ((rdy_cnt % 3) == 2) : 1'b1;
  end

  // monitor: pops expected members at each transfer, checks held offers
  bit stalled = 0;
  int h_a, h_b, h_row;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (stalled) begin
        check(op_valid, "R7 valid held", int'(op_valid), 1);
        check(rd_a_idx == h_a && rd_b_idx == h_b && int'(acc_row) == h_row,
              "R7 indices held", int'(acc_row), h_row);
      end
      stalled = 0;
      if (op_valid) begin
        if (op_ready) begin
          if (q.size() == 0) begin
            check(1'b0, "R6/R8 unexpected transfer", int'(acc_row), -1);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(int'(rd_a_idx) == e.a, "R2 source a", int'(rd_a_idx), e.a);
            check(int'(rd_b_idx) == e.b, "R2 source b", int'(rd_b_idx), e.b);
            check(int'(acc_row) == e.row, "R3/R4 row", int'(acc_row), e.row);
          end
        end else begin
          stalled = 1;
          h_a = rd_a_idx; h_b = rd_b_idx; h_row = acc_row;
        end
      end
    end
  end

  task automatic run_op(input bit sz, input logic [3:0] fa, input logic [3:0] fb,
                        input logic [2:0] of, input bit g4, input bit hv,
                        input logic [31:0] sv, input bit de, input bit he,
                        input bit restart);
    int g, strd, first, ba, bb, ew, cyc;
    bit undef;
    g     = g4 ? 4 : 2;
    strd  = ROWS / g;
    first = int'((64'(sv) + 64'(of)) % 64'(strd));
    ba    = g4 ? int'(fa[2:0]) * 4 : int'(fa) * 2;
    bb    = g4 ? int'(fb[2:0]) * 4 : int'(fb) * 2;
    undef = hv ? !he : (sz && !de);
    ew    = hv ? 16 : (sz ? 64 : 32);
    if (!undef)
      for (int r = 0; r < g; r++) q.push_back('{ba + r, bb + r, first + r * strd});
    @(negedge clk);
    size_bit = sz; src_a_fld = fa; src_b_fld = fb; ofs = of; grp4 = g4;
    half_var = hv; sel_val = sv; dbl_en = de; half_en = he; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      // R9: new fields with a start while busy must be ignored
      src_a_fld = ~fa; src_b_fld = ~fb; ofs = ~of; sel_val = ~sv;
      size_bit = ~sz; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    #1;
    while (!done && cyc < 100) begin
      @(negedge clk); #1; cyc++;
    end
    check(done, "R8 done seen", int'(done), 1);
    check(undef_exc == undef, "R6 exception flag", int'(undef_exc), int'(undef));
    check(!op_valid, "R8 no offer with done", int'(op_valid), 0);
    check(q.size() == 0, "R8 member count", q.size(), 0);
    if (!undef) begin
      check(int'(elem_bits) == ew, "R5 element width", int'(elem_bits), ew);
      check(int'(lanes) == VLEN / ew, "R5 lane count", int'(lanes), VLEN / ew);
    end
    @(negedge clk); #1;
    check(!done && !undef_exc, "R6/R8 single-cycle pulse", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!op_valid, "R10 valid after reset", int'(op_valid), 0);
    check(!done, "R10 done after reset", int'(done), 0);
    check(!undef_exc, "R10 exc after reset", int'(undef_exc), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) begin
      sel_fld = 2'(s);
      #1;
      check(int'(sel_idx) == 8 + s, "R1 select index", int'(sel_idx), 8 + s);
    end
    // R2/R3 group of two, single precision
    run_op(0, 4'd5, 4'd9, 3'd3, 0, 0, 32'd10, 0, 0, 0);
    // R3/R4 group of four, double precision enabled
    run_op(1, 4'd6, 4'd3, 3'd7, 1, 0, 32'd100, 1, 0, 0);
    // R3 select value wraps past 2^32
    run_op(0, 4'd15, 4'd0, 3'd7, 1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    // R5 half-precision variant, size bit ignored
    run_op(1, 4'd2, 4'd14, 3'd1, 0, 1, 32'd33, 0, 1, 0);
    // R6 undefined cases
    run_op(1, 4'd1, 4'd2, 3'd0, 0, 0, 32'd0, 0, 1, 0);
    run_op(0, 4'd1, 4'd2, 3'd0, 1, 1, 32'd0, 1, 0, 0);
    // R7 stalls
    stall_mode = 1;
    run_op(0, 4'd7, 4'd11, 3'd5, 1, 0, 32'd77, 0, 0, 0);
    run_op(1, 4'd3, 4'd4, 3'd2, 0, 0, 32'd31, 1, 0, 0);
    stall_mode = 0;
    // R9 restart while busy
    run_op(0, 4'd4, 4'd8, 3'd1, 1, 0, 32'd5, 1, 1, 1);
    run_op(1, 4'd9, 4'd12, 3'd6, 0, 0, 32'd1234, 1, 1, 1);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule